// File: doc/BRIEF.md
# Priority Context Selection Unit

This unit chooses which hardware context of a block-multithreaded core runs next. Every context has its own priority value, written through a single write port, and a stall bit that external set and clear pulses raise and drop. A larger priority value marks a more important thread. A stalled context is waiting on memory and is never picked.

Selection runs after a trigger. A trigger is a cache miss, a failed synchronization test, or any priority write. Writes therefore preempt the running context. Among the eligible contexts the unit takes the one with the largest priority. When several contexts tie at that value, it rotates among them: the search starts just after the last context it picked. Every change of the running context opens a drain window of fixed length, reported on `switchBusy`. Triggers that arrive inside the window are remembered and take effect once the window closes. When no context is eligible, the unit drops `curValid` and waits for a stall bit to clear.

Top module: `prio_ctx_sel`

## Requirements
- R1: While reset is held, `curValid`=0, `switchBusy`=0 and `curCtx`=0. The first clock edge after reset is released runs a selection. With all priorities at 0 and no stalls, that selection picks context 0 and raises `curValid` and `switchBusy`.
- R2: The selected context has the largest priority value among the contexts whose stall bit is clear. Priorities compare as unsigned numbers.
- R3: A context whose stall bit is set is never selected. `stallSet` bit i sets the stall of context i and `stallClr` bit i clears it. When both pulse in the same cycle, the set wins.
- R4: When several eligible contexts tie at the maximum, the unit picks the first one found searching upward with wrap-around. The search starts at the index one above the last selected context. After reset that "last selected" index is NUM_CTX-1.
- R5: `missEvt` or `syncFailEvt` high in the cycle before clock edge E causes a selection whose result appears on `curCtx` after edge E+1, provided `switchBusy` is low.
- R6: `prioWrEn` writes `prioWrData` into the priority of context `prioWrIdx` at the clock edge. It also triggers a selection with the same timing as R5, and that selection uses the written value.
- R7: A selection that changes `curCtx`, or raises `curValid`, holds `switchBusy` high for exactly DRAIN_CYC (default 5) cycles. `curCtx` does not change while `switchBusy` is high.
- R8: A trigger captured while `switchBusy` is high is kept pending. This includes a trigger in the last busy cycle. The pending selection takes effect at the second clock edge after `switchBusy` falls.
- R9: If a selection finds no eligible context, `curValid` goes to 0, `curCtx` keeps its value and `switchBusy` stays 0. While `curValid` is 0, any stall clear triggers a selection with the timing of R5.
- R10: A selection that returns the context already running with `curValid`=1 changes nothing and does not raise `switchBusy`.

Two cases fall under R10. One is a priority write that leaves the running context as the unique maximum. The other is a miss when the running context stays the only maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prioWrEn | input | 1 | Priority write strobe (also a selection trigger) |
| prioWrIdx | input | IDX_W | Context whose priority is written |
| prioWrData | input | PRIO_W | New priority value |
| stallSet | input | NUM_CTX | Per-context stall set pulses |
| stallClr | input | NUM_CTX | Per-context stall clear pulses |
| missEvt | input | 1 | Cache miss of the running context (trigger) |
| syncFailEvt | input | 1 | Failed synchronization test (trigger) |
| curCtx | output | IDX_W | Index of the selected context |
| curValid | output | 1 | A context is selected and eligible |
| switchBusy | output | 1 | Pipeline drain window after a context change |

## Verification
The two functions that can collide are the drain counter expiring and a new trigger being captured. A trigger can land on the very edge where the window closes, and a priority write can land on the edge where a pending selection is evaluated. The bench provokes the first case by firing a miss, together with a stall of the running context, in the last busy cycle. It then requires `switchBusy` low with the old context one edge later, and the next-best context one edge after that. It provokes the second case by writing a higher priority into another context in the middle of a window. It judges that case by requiring the switch to wait for the window to end and then pick the written context.

// File: rtl/prio_ctx_pkg.sv
package prio_ctx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic commit;     // load the picked context as current
    logic dropValid;  // nothing eligible: invalidate current
  } ctrlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic anyElig;
    logic pickNew;    // picked context differs from the running one
    logic curValid;
  } dpStat_t;
endpackage

// File: rtl/prio_ctx_pick.sv
module prio_ctx_pick #(
  parameter int NUM_CTX = 16,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_CTX*PRIO_W-1:0] prioFlat,
  input  logic [NUM_CTX-1:0]        eligVec,
  input  logic [IDX_W-1:0]          rrPtr,
  output logic                      anyElig,
  output logic [IDX_W-1:0]          pickIdx
);
  logic [PRIO_W-1:0]  prioArr [NUM_CTX];
  logic [PRIO_W-1:0]  maxPrio;
  logic [NUM_CTX-1:0] tieVec;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_unpack
    assign prioArr[g] = prioFlat[g*PRIO_W +: PRIO_W];
    assign tieVec[g]  = eligVec[g] && (prioArr[g] == maxPrio);
  end

  assign anyElig = |eligVec;

  always_comb begin
    maxPrio = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (eligVec[i] && (prioArr[i] > maxPrio)) maxPrio = prioArr[i];
    end
  end

  // rotating search over the tie set, starting above rrPtr
  always_comb begin
    logic found;
    found   = 1'b0;
    pickIdx = rrPtr;
    for (int k = 1; k <= NUM_CTX; k++) begin
      int s;
      s = int'(rrPtr) + k;
      if (s >= NUM_CTX) s = s - NUM_CTX;
      if (!found && tieVec[s]) begin
        found   = 1'b1;
        pickIdx = IDX_W'(s);
      end
    end
  end
endmodule

// File: rtl/prio_ctx_dp.sv
module prio_ctx_dp
  import prio_ctx_pkg::*;
#(
  parameter int NUM_CTX = 16,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prioWrEn,
  input  logic [IDX_W-1:0]          prioWrIdx,
  input  logic [PRIO_W-1:0]         prioWrData,
  input  logic [NUM_CTX-1:0]        stallSet,
  input  logic [NUM_CTX-1:0]        stallClr,
  input  ctrlStrb_t                 strb,
  output dpStat_t                   stat,
  output logic [IDX_W-1:0]          curCtx,
  output logic                      curValid,
  output logic [NUM_CTX-1:0]        stallVec
);
  logic [NUM_CTX*PRIO_W-1:0] prioFlat;
  logic [IDX_W-1:0]          rrPtr;
  logic [IDX_W-1:0]          pickIdx;
  logic                      anyElig;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_prio
    always_ff @(posedge clk) begin
      if (!rst_n)
        prioFlat[g*PRIO_W +: PRIO_W] <= '0;
      else if (prioWrEn && (prioWrIdx == IDX_W'(g)))
        prioFlat[g*PRIO_W +: PRIO_W] <= prioWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stallVec <= '0;
    else        stallVec <= (stallVec & ~stallClr) | stallSet;
  end

  prio_ctx_pick #(.NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) pick_i (
    .prioFlat(prioFlat),
    .eligVec (~stallVec),
    .rrPtr   (rrPtr),
    .anyElig (anyElig),
    .pickIdx (pickIdx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curCtx   <= '0;
      curValid <= 1'b0;
      rrPtr    <= IDX_W'(NUM_CTX - 1);
    end else if (strb.commit) begin
      curCtx   <= pickIdx;
      curValid <= 1'b1;
      rrPtr    <= pickIdx;
    end else if (strb.dropValid) begin
      curValid <= 1'b0;
    end
  end

  assign stat.anyElig  = anyElig;
  assign stat.pickNew  = !curValid || (pickIdx != curCtx);
  assign stat.curValid = curValid;
endmodule

// File: rtl/prio_ctx_ctrl.sv
module prio_ctx_ctrl
  import prio_ctx_pkg::*;
#(
  parameter int DRAIN_CYC = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      missEvt,
  input  logic      syncFailEvt,
  input  logic      prioWrEn,
  input  logic      stallClrAny,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      switchBusy
);
  localparam int CNT_W = $clog2(DRAIN_CYC + 1);

  logic             pendQ;
  logic [CNT_W-1:0] drainCnt;
  logic             evalNow;
  logic             newTrig;

  assign newTrig = missEvt || syncFailEvt || prioWrEn || (stallClrAny && !stat.curValid);
  assign evalNow = pendQ && (drainCnt == '0);

  assign strb.commit    = evalNow && stat.anyElig && stat.pickNew;
  assign strb.dropValid = evalNow && !stat.anyElig;

  always_ff @(posedge clk) begin
    if (!rst_n) pendQ <= 1'b1;
    else        pendQ <= newTrig || (pendQ && !evalNow);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                drainCnt <= '0;
    else if (strb.commit)      drainCnt <= CNT_W'(DRAIN_CYC);
    else if (drainCnt != '0)   drainCnt <= drainCnt - 1'b1;
  end

  assign switchBusy = (drainCnt != '0);
endmodule

// File: rtl/prio_ctx_sel.sv
module prio_ctx_sel
  import prio_ctx_pkg::*;
#(
  parameter int NUM_CTX   = 16,
  parameter int PRIO_W    = 8,
  parameter int DRAIN_CYC = 5,
  localparam int IDX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prioWrEn,
  input  logic [IDX_W-1:0]   prioWrIdx,
  input  logic [PRIO_W-1:0]  prioWrData,
  input  logic [NUM_CTX-1:0] stallSet,
  input  logic [NUM_CTX-1:0] stallClr,
  input  logic               missEvt,
  input  logic               syncFailEvt,
  output logic [IDX_W-1:0]   curCtx,
  output logic               curValid,
  output logic               switchBusy
);
  ctrlStrb_t          strb;
  dpStat_t            stat;
  logic [NUM_CTX-1:0] stallVec;

  prio_ctx_dp #(.NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .prioWrEn  (prioWrEn),
    .prioWrIdx (prioWrIdx),
    .prioWrData(prioWrData),
    .stallSet  (stallSet),
    .stallClr  (stallClr),
    .strb      (strb),
    .stat      (stat),
    .curCtx    (curCtx),
    .curValid  (curValid),
    .stallVec  (stallVec)
  );

  prio_ctx_ctrl #(.DRAIN_CYC(DRAIN_CYC)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .missEvt    (missEvt),
    .syncFailEvt(syncFailEvt),
    .prioWrEn   (prioWrEn),
    .stallClrAny(|stallClr),
    .stat       (stat),
    .strb       (strb),
    .switchBusy (switchBusy)
  );
endmodule

// File: rtl/prio_ctx_sel_chk.sv
module prio_ctx_sel_chk #(
  parameter int NUM_CTX   = 16,
  parameter int IDX_W     = 4,
  parameter int DRAIN_CYC = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [IDX_W-1:0]   curCtx,
  input logic               curValid,
  input logic               switchBusy,
  input logic [NUM_CTX-1:0] stallVec
);
  logic [NUM_CTX-1:0] stallPrev;
  logic [31:0]        busyRun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stallPrev <= '0;
      busyRun   <= '0;
    end else begin
      stallPrev <= stallVec;
      busyRun   <= switchBusy ? busyRun + 1 : 32'd0;
    end
  end

  // R7
  busy_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switchBusy |-> curValid);

  // R7
  ctx_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switchBusy |=> $stable(curCtx));

  // R7
  drain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busyRun <= 32'(DRAIN_CYC));

  // R3
  pick_unstalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(switchBusy) |-> !stallPrev[curCtx]);

  // R9
  drop_keeps_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(curValid) |-> $stable(curCtx));
endmodule

bind prio_ctx_sel prio_ctx_sel_chk #(
  .NUM_CTX(NUM_CTX), .IDX_W(IDX_W), .DRAIN_CYC(DRAIN_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .curCtx    (curCtx),
  .curValid  (curValid),
  .switchBusy(switchBusy),
  .stallVec  (stallVec)
);

// File: tb/prio_ctx_sel_tb_top.sv
`timescale 1ns/1ps
module prio_ctx_sel_tb_top;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         prioWrEn = 1'b0;
  logic [3:0]   prioWrIdx = '0;
  logic [7:0]   prioWrData = '0;
  logic [N-1:0] stallSet = '0;
  logic [N-1:0] stallClr = '0;
  logic         missEvt = 1'b0;
  logic         syncFailEvt = 1'b0;
  logic [3:0]   curCtx;
  logic         curValid;
  logic         switchBusy;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  prio_ctx_sel #(.NUM_CTX(N), .PRIO_W(8), .DRAIN_CYC(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .prioWrEn(prioWrEn), .prioWrIdx(prioWrIdx),
    .prioWrData(prioWrData), .stallSet(stallSet), .stallClr(stallClr),
    .missEvt(missEvt), .syncFailEvt(syncFailEvt), .curCtx(curCtx),
    .curValid(curValid), .switchBusy(switchBusy)
  );

  typedef struct packed {
    logic       wrEn;
    logic [3:0] wrIdx;
    logic [7:0] wrData;
    logic [15:0] sSet;
    logic [15:0] sClr;
    logic       miss;
    logic       sync;
    logic       expV;
    logic [3:0] expCtx;
  } step_t;

  localparam step_t STEPS [10] = '{
    '{1'b1, 4'd5, 8'd10,  16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd5}, // R6 R2
    '{1'b1, 4'd9, 8'd10,  16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd9}, // R4 tie rotates
    '{1'b0, 4'd0, 8'd0,   16'h0200, 16'h0000, 1'b1, 1'b0, 1'b1, 4'd5}, // R3 ctx9 stalled
    '{1'b0, 4'd0, 8'd0,   16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 4'd5}, // R5 sync fail, same
    '{1'b0, 4'd0, 8'd0,   16'h0000, 16'h0200, 1'b1, 1'b0, 1'b1, 4'd9}, // R4 unstall, rotate
    '{1'b1, 4'd2, 8'd200, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 new max
    '{1'b1, 4'd2, 8'd0,   16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd5}, // R4 search from 3
    '{1'b0, 4'd0, 8'd0,   16'hFFFF, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd5}, // R9 none eligible
    '{1'b0, 4'd0, 8'd0,   16'h0000, 16'h0001, 1'b0, 1'b0, 1'b1, 4'd0}, // R9 clear wakes
    '{1'b0, 4'd0, 8'd0,   16'h0000, 16'hFFFF, 1'b1, 1'b0, 1'b1, 4'd5}  // R5 miss, max tier
  };

  function automatic string stepTag(input int i);
    case (i)
      0: return "R6";
      1: return "R4";
      2: return "R3";
      3: return "R5";
      4: return "R4";
      5: return "R2";
      6: return "R4";
      7: return "R9";
      8: return "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic we, input logic [3:0] wi, input logic [7:0] wd,
                       input logic [15:0] ss, input logic [15:0] sc,
                       input logic m, input logic sf);
    prioWrEn = we; prioWrIdx = wi; prioWrData = wd;
    stallSet = ss; stallClr = sc; missEvt = m; syncFailEvt = sf;
    @(negedge clk);
    prioWrEn = 1'b0; stallSet = '0; stallClr = '0; missEvt = 1'b0; syncFailEvt = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 20; k++) begin
      if (!switchBusy) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(curValid == 1'b0 && switchBusy == 1'b0 && curCtx == 4'd0, "R1 reset",
        {curValid, switchBusy, curCtx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(curValid && switchBusy && curCtx == 4'd0, "R1 first pick",
        {curValid, switchBusy, curCtx}, 6'h30);
    waitIdle();

    for (int i = 0; i < 10; i++) begin
      pulse(STEPS[i].wrEn, STEPS[i].wrIdx, STEPS[i].wrData, STEPS[i].sSet,
            STEPS[i].sClr, STEPS[i].miss, STEPS[i].sync);
      @(negedge clk);
      waitIdle();
      chk(curValid == STEPS[i].expV && curCtx == STEPS[i].expCtx, stepTag(i),
          {curValid, curCtx}, {STEPS[i].expV, STEPS[i].expCtx});
    end

    // R5 R6 R7: timing of a preempting write and length of the drain window
    pulse(1'b1, 4'd12, 8'd50, '0, '0, 1'b0, 1'b0);
    chk(curCtx == 4'd5 && !switchBusy, "R6 one edge later", curCtx, 5);
    @(negedge clk);
    chk(curCtx == 4'd12 && switchBusy, "R5 two edges later", curCtx, 12);
    begin
      int n;
      n = 1;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (switchBusy) n++;
        else break;
      end
      chk(n == 5, "R7 drain length", n, 5);
    end

    // R10: write leaves current as unique maximum
    pulse(1'b1, 4'd12, 8'd60, '0, '0, 1'b0, 1'b0);
    @(negedge clk);
    chk(curCtx == 4'd12 && !switchBusy, "R10 raise own prio", {switchBusy, curCtx}, 12);
    pulse(1'b1, 4'd3, 8'd20, '0, '0, 1'b0, 1'b0);
    @(negedge clk);
    chk(curCtx == 4'd12 && !switchBusy, "R10 lower write", {switchBusy, curCtx}, 12);

    // R8: write during drain waits for the window to close
    pulse(1'b1, 4'd7, 8'd100, '0, '0, 1'b0, 1'b0);
    @(negedge clk);
    chk(curCtx == 4'd7 && switchBusy, "R2 switch to 7", curCtx, 7);
    pulse(1'b1, 4'd1, 8'd120, '0, '0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(curCtx == 4'd7 && switchBusy, "R8 held during drain", {switchBusy, curCtx}, 23);
    @(negedge clk);
    chk(curCtx == 4'd7 && !switchBusy, "R8 window closed", {switchBusy, curCtx}, 7);
    @(negedge clk);
    chk(curCtx == 4'd1 && switchBusy, "R8 pending applied", {switchBusy, curCtx}, 17);

    // R8: miss in the last busy cycle
    repeat (4) @(negedge clk);
    chk(switchBusy == 1'b1, "R7 last busy cycle", switchBusy, 1);
    pulse(1'b0, 4'd0, 8'd0, 16'h0002, '0, 1'b1, 1'b0);
    chk(curCtx == 4'd1 && !switchBusy, "R8 edge collision", {switchBusy, curCtx}, 1);
    @(negedge clk);
    chk(curCtx == 4'd7 && switchBusy, "R8 collision result", {switchBusy, curCtx}, 23);

    // R9: nothing eligible holds, write does not wake, clear does
    waitIdle();
    pulse(1'b0, 4'd0, 8'd0, 16'hFFFF, '0, 1'b1, 1'b0);
    @(negedge clk);
    chk(!curValid && curCtx == 4'd7 && !switchBusy, "R9 all stalled",
        {curValid, switchBusy, curCtx}, 7);
    pulse(1'b1, 4'd4, 8'd255, '0, '0, 1'b0, 1'b0);
    @(negedge clk);
    chk(!curValid && curCtx == 4'd7 && !switchBusy, "R9 write while idle",
        {curValid, switchBusy, curCtx}, 7);
    pulse(1'b0, 4'd0, 8'd0, '0, 16'h0010, 1'b0, 1'b0);
    @(negedge clk);
    chk(curValid && curCtx == 4'd4, "R9 clear wakes", {curValid, curCtx}, 20);

    // R3: set and clear together, set wins
    waitIdle();
    pulse(1'b0, 4'd0, 8'd0, 16'h0010, 16'h0010, 1'b1, 1'b0);
    @(negedge clk);
    chk(!curValid && curCtx == 4'd4, "R3 set beats clear", {curValid, curCtx}, 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 5000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule